// File: doc/BRIEF.md
# DRAM Page Miss Detector

This block decides whether a memory request can reuse the DRAM row that is already open, or whether the controller has to close that row and open a new one. It remembers the row and bank of the last accepted request. Each new request is compared against them. A column counter can step the column address during a burst. If a step carries out of the column bits that make up one page, the open page counts as left, and the next request reports a miss.

The miss decision can come from either side of a bidirectional pin, chosen by one configuration bit. In drive mode the block computes the decision, puts it on the pin and enables the pin driver. In sense mode the pin driver is off and the processor supplies the decision through the pin. The row and bank tracking continues in both modes. The miss flag returned to the controller is forced low unless the address strobe and the chip select are both high in that cycle. The block has no registers on its outputs: the flag is a combinational function of the current request and of state captured on earlier clock edges.

Top module: `page_miss_detector`

## Requirements
- R1: After reset, the first request with both `addr_strobe` and `chip_sel` high reports a miss.
- R2: A qualified request whose row differs from the row of the previous qualified request reports a miss.
- R3: A qualified request whose bank differs from the previous qualified bank reports a miss. A request with the same row and bank, and no pending crossing, reports a hit (flag low).
- R4: A cycle with `col_step` high and no qualified request checks whether the column bits below the page size are all ones. If so, the step carries out of the page and the next qualified request reports a miss. A step from any other column value has no such effect.
- R5: `cfg_page_sz` sets the page size: 0 gives 512 locations (9 column bits), 1 gives 1024 (10 bits), 2 gives 2048 (11 bits) and 3 gives 4096 (12 bits).
- R6: `page_miss` and `miss_pin_out` stay low in every cycle where `addr_strobe` and `chip_sel` are not both high. Such cycles do not change the stored row or bank.
- R7: A qualified request captures its row and bank and clears any pending crossing. A `col_step` in the same cycle as a qualified request is ignored.
- R8: With `cfg_miss_drive` = 1, `miss_pin_oe` is high and `page_miss` equals the computed decision. With 0, `miss_pin_oe` is low and `page_miss` follows `miss_pin_in` during qualified requests. In both modes `miss_pin_out` carries the computed decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_strobe | input | 1 | Request strobe |
| chip_sel | input | 1 | Select that qualifies the strobe |
| row_addr | input | ROW_W | Row address of the request |
| col_addr | input | COL_W | Current column address |
| bank_sel | input | BANK_W | Bank of the request |
| col_step | input | 1 | Column counter advances from `col_addr` this cycle |
| cfg_page_sz | input | 2 | Page size code |
| cfg_miss_drive | input | 1 | 1: the block drives the miss pin; 0: the pin is sensed |
| miss_pin_in | input | 1 | Value sensed on the miss pin |
| miss_pin_out | output | 1 | Value driven onto the miss pin |
| miss_pin_oe | output | 1 | Output enable of the miss pin driver |
| page_miss | output | 1 | Miss decision used by the controller |

## Verification
The bench uses the defaults: 13 row bits, 12 column bits and 2 bank bits. With 12 column bits, every page size code can be tested. At the largest size the page mask covers the whole column, so only the all-ones column 0xFFF carries out. At each smaller size, the bench steps from a column that is all ones in the page bits but not in the next bit up. This separates neighbouring page sizes. The bench also tests a step in the same cycle as a request, and sense mode with the row changing while the pin says hit.

// File: rtl/pmd_pkg.sv
package pmd_pkg;

    // Column bits in the smallest page (512 locations)
    localparam int unsigned PAGE_BASE_BITS = 9;

    typedef enum logic [1:0] {
        PG_512  = 2'd0,
        PG_1K   = 2'd1,
        PG_2K   = 2'd2,
        PG_4K   = 2'd3
    } page_sz_e;

    typedef enum logic {
        PIN_SENSE = 1'b0,
        PIN_DRIVE = 1'b1
    } pin_dir_e;

    // Individual reasons for leaving the open page
    typedef struct packed {
        logic cold;       // nothing opened since reset
        logic row_diff;   // row changed
        logic bank_diff;  // bank changed
        logic crossed;    // column carried out of the page
    } miss_cause_t;

    function automatic int unsigned page_col_bits(page_sz_e sz);
        return PAGE_BASE_BITS + 32'(sz);
    endfunction

    function automatic logic any_cause(miss_cause_t c);
        return |c;
    endfunction

endpackage

// File: rtl/pmd_open_page.sv
module pmd_open_page #(
    parameter int unsigned ROW_W  = 13,
    parameter int unsigned BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ROW_W-1:0]  row_addr,
    input  logic [BANK_W-1:0] bank_sel,
    output logic              cold,
    output logic              row_diff,
    output logic              bank_diff
);

    logic              open_vld;
    logic [ROW_W-1:0]  open_row;
    logic [BANK_W-1:0] open_bank;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_vld  <= 1'b0;
            open_row  <= '0;
            open_bank <= '0;
        end else if (start) begin
            open_vld  <= 1'b1;
            open_row  <= row_addr;
            open_bank <= bank_sel;
        end
    end

    always_comb begin
        cold      = !open_vld;
        row_diff  = (row_addr != open_row);
        bank_diff = (bank_sel != open_bank);
    end

endmodule

// File: rtl/pmd_boundary.sv
module pmd_boundary
    import pmd_pkg::*;
#(
    parameter int unsigned COL_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             col_step,
    input  logic [COL_W-1:0] col_addr,
    input  page_sz_e         page_sz,
    output logic             crossed
);

    logic [COL_W-1:0] page_mask;
    logic             carry_out;
    logic             cross_q;

    // Bit i belongs to the page offset when it lies below the page size
    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        assign page_mask[i] = (page_col_bits(page_sz) > unsigned'(i));
    end

    // Incrementing an all-ones offset carries into the next page
    assign carry_out = &(col_addr | ~page_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            cross_q <= 1'b0;
        end else if (start) begin
            cross_q <= 1'b0;
        end else if (col_step && carry_out) begin
            cross_q <= 1'b1;
        end
    end

    assign crossed = cross_q;

endmodule

// File: rtl/pmd_pin.sv
module pmd_pin
    import pmd_pkg::*;
(
    input  logic        start,
    input  miss_cause_t cause,
    input  pin_dir_e    dir,
    input  logic        pin_in,
    output logic        page_miss,
    output logic        pin_out,
    output logic        pin_oe
);

    logic own_miss;

    always_comb begin
        own_miss = any_cause(cause);
        pin_out  = start && own_miss;
        pin_oe   = (dir == PIN_DRIVE);
        if (dir == PIN_DRIVE) begin
            page_miss = start && own_miss;
        end else begin
            page_miss = start && pin_in;
        end
    end

endmodule

// File: rtl/page_miss_detector.sv
module page_miss_detector
    import pmd_pkg::*;
#(
    parameter int unsigned ROW_W  = 13,
    parameter int unsigned COL_W  = 12,
    parameter int unsigned BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_strobe,
    input  logic              chip_sel,
    input  logic [ROW_W-1:0]  row_addr,
    input  logic [COL_W-1:0]  col_addr,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic              col_step,
    input  logic [1:0]        cfg_page_sz,
    input  logic              cfg_miss_drive,
    input  logic              miss_pin_in,
    output logic              miss_pin_out,
    output logic              miss_pin_oe,
    output logic              page_miss
);

    logic        start;
    miss_cause_t cause;
    page_sz_e    page_sz;
    pin_dir_e    pin_dir;

    assign start   = addr_strobe && chip_sel;
    assign page_sz = page_sz_e'(cfg_page_sz);
    assign pin_dir = pin_dir_e'(cfg_miss_drive);

    pmd_open_page #(
        .ROW_W  (ROW_W),
        .BANK_W (BANK_W)
    ) u_open (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .row_addr  (row_addr),
        .bank_sel  (bank_sel),
        .cold      (cause.cold),
        .row_diff  (cause.row_diff),
        .bank_diff (cause.bank_diff)
    );

    pmd_boundary #(
        .COL_W (COL_W)
    ) u_bound (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .col_step (col_step),
        .col_addr (col_addr),
        .page_sz  (page_sz),
        .crossed  (cause.crossed)
    );

    pmd_pin u_pin (
        .start     (start),
        .cause     (cause),
        .dir       (pin_dir),
        .pin_in    (miss_pin_in),
        .page_miss (page_miss),
        .pin_out   (miss_pin_out),
        .pin_oe    (miss_pin_oe)
    );

endmodule

// File: rtl/pmd_checker.sv
module pmd_checker #(
    parameter int unsigned ROW_W  = 13,
    parameter int unsigned BANK_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              addr_strobe,
    input logic              chip_sel,
    input logic [ROW_W-1:0]  row_addr,
    input logic [BANK_W-1:0] bank_sel,
    input logic              miss_pin_in,
    input logic              miss_pin_out,
    input logic              miss_pin_oe,
    input logic              page_miss
);

    logic              qual;
    logic              seen;
    logic [ROW_W-1:0]  last_row;
    logic [BANK_W-1:0] last_bank;

    assign qual = addr_strobe && chip_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen      <= 1'b0;
            last_row  <= '0;
            last_bank <= '0;
        end else if (qual) begin
            seen      <= 1'b1;
            last_row  <= row_addr;
            last_bank <= bank_sel;
        end
    end

    // R6
    unqual_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !qual |-> (!page_miss && !miss_pin_out));

    // R1
    first_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (qual && !seen) |-> miss_pin_out);

    // R2
    row_change_chk: assert property (@(posedge clk) disable iff (rst)
        (qual && seen && (row_addr != last_row)) |-> miss_pin_out);

    // R3
    bank_change_chk: assert property (@(posedge clk) disable iff (rst)
        (qual && seen && (bank_sel != last_bank)) |-> miss_pin_out);

    // R8
    sense_mode_chk: assert property (@(posedge clk) disable iff (rst)
        !miss_pin_oe |-> (page_miss == (qual && miss_pin_in)));

    // R8
    drive_mode_chk: assert property (@(posedge clk) disable iff (rst)
        miss_pin_oe |-> (page_miss == miss_pin_out));

endmodule

bind page_miss_detector pmd_checker #(
    .ROW_W  (ROW_W),
    .BANK_W (BANK_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .addr_strobe  (addr_strobe),
    .chip_sel     (chip_sel),
    .row_addr     (row_addr),
    .bank_sel     (bank_sel),
    .miss_pin_in  (miss_pin_in),
    .miss_pin_out (miss_pin_out),
    .miss_pin_oe  (miss_pin_oe),
    .page_miss    (page_miss)
);

// File: tb/page_miss_detector_tb.sv
`timescale 1ns/1ps
module page_miss_detector_tb;

    localparam int unsigned ROW_W  = 13;
    localparam int unsigned COL_W  = 12;
    localparam int unsigned BANK_W = 2;

    logic              clk = 1'b0;
    logic              rst;
    logic              addr_strobe;
    logic              chip_sel;
    logic [ROW_W-1:0]  row_addr;
    logic [COL_W-1:0]  col_addr;
    logic [BANK_W-1:0] bank_sel;
    logic              col_step;
    logic [1:0]        cfg_page_sz;
    logic              cfg_miss_drive;
    logic              miss_pin_in;
    logic              miss_pin_out;
    logic              miss_pin_oe;
    logic              page_miss;

    always #2.5 clk = ~clk;

    page_miss_detector #(
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .BANK_W (BANK_W)
    ) u_dut (
        .clk            (clk),
        .rst            (rst),
        .addr_strobe    (addr_strobe),
        .chip_sel       (chip_sel),
        .row_addr       (row_addr),
        .col_addr       (col_addr),
        .bank_sel       (bank_sel),
        .col_step       (col_step),
        .cfg_page_sz    (cfg_page_sz),
        .cfg_miss_drive (cfg_miss_drive),
        .miss_pin_in    (miss_pin_in),
        .miss_pin_out   (miss_pin_out),
        .miss_pin_oe    (miss_pin_oe),
        .page_miss      (page_miss)
    );

    typedef struct {
        logic  pm;
        logic  out;
        logic  oe;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    event sample_ev;
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;

    // Reference state built from the requirements
    bit               m_valid;
    logic [ROW_W-1:0] m_row;
    logic [BANK_W-1:0] m_bank;
    bit               m_cross;

    task automatic step(input logic s, input logic cs, input logic [ROW_W-1:0] row,
                        input logic [COL_W-1:0] col, input logic [BANK_W-1:0] bank,
                        input logic stp, input logic pin, input string tag);
        exp_t e;
        bit   q;
        bit   own;
        logic [COL_W-1:0] mask;
        @(negedge clk);
        addr_strobe = s;
        chip_sel    = cs;
        row_addr    = row;
        col_addr    = col;
        bank_sel    = bank;
        col_step    = stp;
        miss_pin_in = pin;
        q    = s && cs;
        own  = !m_valid || (row != m_row) || (bank != m_bank) || m_cross;
        mask = COL_W'((1 << (9 + int'(cfg_page_sz))) - 1);
        e.pm  = q ? (cfg_miss_drive ? own : pin) : 1'b0;
        e.out = q ? own : 1'b0;
        e.oe  = cfg_miss_drive;
        e.tag = tag;
        exp_q.push_back(e);
        #1 -> sample_ev;
        @(posedge clk);
        if (q) begin
            m_valid = 1'b1;
            m_row   = row;
            m_bank  = bank;
            m_cross = 1'b0;
        end else if (stp && ((col & mask) == mask)) begin
            m_cross = 1'b1;
        end
    endtask

    // Monitor: compares outputs against queued expectations
    initial begin
        forever begin
            @(sample_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_tests++;
                if (page_miss !== e.pm || miss_pin_out !== e.out || miss_pin_oe !== e.oe) begin
                    n_fail++;
                    $display("FAIL %s: actual pm=%b out=%b oe=%b expected pm=%b out=%b oe=%b",
                             e.tag, page_miss, miss_pin_out, miss_pin_oe, e.pm, e.out, e.oe);
                end
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1..R8 run: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        addr_strobe = 0; chip_sel = 0; row_addr = '0; col_addr = '0; bank_sel = '0;
        col_step = 0; miss_pin_in = 0; cfg_page_sz = 2'd0; cfg_miss_drive = 1'b1;
        m_valid = 0; m_row = '0; m_bank = '0; m_cross = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        step(0, 0, 13'd0, 12'd0, 2'd0, 0, 0, "R6 reset idle");
        step(1, 1, 13'd5, 12'd0, 2'd1, 0, 0, "R1 first access");
        step(1, 1, 13'd5, 12'd3, 2'd1, 0, 0, "R3 same page hit");
        step(1, 1, 13'd6, 12'd3, 2'd1, 0, 0, "R2 row change");
        step(1, 1, 13'd6, 12'd4, 2'd1, 0, 0, "R3 hit after row change");
        step(1, 1, 13'd6, 12'd4, 2'd2, 0, 0, "R3 bank change");
        step(1, 0, 13'd9, 12'd4, 2'd3, 0, 0, "R6 strobe without select");
        step(0, 1, 13'd9, 12'd4, 2'd3, 0, 0, "R6 select without strobe");
        step(1, 1, 13'd6, 12'd4, 2'd2, 0, 0, "R6 unqualified left row unchanged");
        // 512-location pages
        step(0, 0, 13'd6, 12'h0FE, 2'd2, 1, 0, "R4 step inside page");
        step(1, 1, 13'd6, 12'h0FF, 2'd2, 0, 0, "R4 no crossing hit");
        step(0, 0, 13'd6, 12'h1FF, 2'd2, 1, 0, "R4 step at boundary");
        step(1, 1, 13'd6, 12'h000, 2'd2, 0, 0, "R4 R5 crossing miss 512");
        step(1, 1, 13'd6, 12'h001, 2'd2, 0, 0, "R7 crossing cleared");
        // 1024
        cfg_page_sz = 2'd1;
        step(0, 0, 13'd6, 12'h1FF, 2'd2, 1, 0, "R5 1K no carry at 0x1FF");
        step(1, 1, 13'd6, 12'h200, 2'd2, 0, 0, "R5 1K hit");
        step(0, 0, 13'd6, 12'h3FF, 2'd2, 1, 0, "R5 1K step at boundary");
        step(1, 1, 13'd6, 12'h400, 2'd2, 0, 0, "R5 1K crossing miss");
        // 2048
        cfg_page_sz = 2'd2;
        step(0, 0, 13'd6, 12'h3FF, 2'd2, 1, 0, "R5 2K no carry at 0x3FF");
        step(1, 1, 13'd6, 12'h400, 2'd2, 0, 0, "R5 2K hit");
        step(0, 0, 13'd6, 12'h7FF, 2'd2, 1, 0, "R5 2K step at boundary");
        step(1, 1, 13'd6, 12'h000, 2'd2, 0, 0, "R5 2K crossing miss");
        // 4096
        cfg_page_sz = 2'd3;
        step(0, 0, 13'd6, 12'h7FF, 2'd2, 1, 0, "R5 4K no carry at 0x7FF");
        step(1, 1, 13'd6, 12'h800, 2'd2, 0, 0, "R5 4K hit");
        step(0, 0, 13'd6, 12'hFFF, 2'd2, 1, 0, "R5 4K step at boundary");
        step(1, 1, 13'd6, 12'h000, 2'd2, 0, 0, "R5 4K crossing miss");
        // Step alongside a qualified request is ignored
        step(1, 1, 13'd6, 12'hFFF, 2'd2, 1, 0, "R7 request with step hit");
        step(1, 1, 13'd6, 12'h000, 2'd2, 0, 0, "R7 same-cycle step ignored");
        // Sense mode
        cfg_miss_drive = 1'b0;
        step(0, 0, 13'd6, 12'h000, 2'd2, 0, 1, "R8 sense idle pin high");
        step(1, 1, 13'd7, 12'h000, 2'd2, 0, 0, "R8 sense row change pin low");
        step(1, 1, 13'd7, 12'h000, 2'd2, 0, 1, "R8 sense same page pin high");
        cfg_miss_drive = 1'b1;
        step(1, 1, 13'd7, 12'h000, 2'd2, 0, 1, "R8 drive ignores pin");
        step(1, 1, 13'd7, 12'h000, 2'd3, 0, 0, "R3 R8 drive bank change");

        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule